// File: doc/BRIEF.md
# Dual-Mode Host Command Port

This block is the host-facing command port of a peripheral. A host sends command and data bytes over one of two physical schemes. The first is an 8-bit parallel bus with three active-low strobes: write, data-write and read. The second is a two-wire serial link that reuses two pins of that same bus, one as clock and one as data. A static mode pin chooses the scheme. An active-low chip select must be low for any strobe or serial activity to count.

All host pins cross into the system clock domain through two-flop synchronizers. Edges are then found on the synchronized copies. In serial mode the sampling edge is not fixed. It is chosen for each access from the serial clock level at the moment the access opens:

- If an access opens with a strobe falling while the serial clock is low, data is taken on rising clock edges.
- If an access opens with chip select falling while the serial clock is high, data is taken on falling clock edges.

Every finished byte is delivered with a one-cycle valid pulse and a tag that tells whether the data-write strobe carried it. The block also drives the read-back data pins while the host reads, and it turns the busy line of the storage engine into a ready flag.

Serial engine states:

- `SER_IDLE` is the reset state and the state outside any access.
- `SER_RISE` samples on rising serial clock edges. It is entered from `SER_IDLE` on a gated strobe fall seen with the serial clock low.
- `SER_FALL` samples on falling serial clock edges. It is entered from `SER_IDLE` on a chip-select fall seen with the serial clock high.
- Both sampling states return to `SER_IDLE` when chip select goes high or when serial mode is left.

Top module: `host_cmd_port`

## Requirements
- R1: With `serial_sel` low, a byte is taken from `d_in` when the write or data-write strobe returns high. With `serial_sel` high, bytes come only from the serial pins.
- R2: While `cs_n` is high, strobe and serial clock activity produces no byte, and `d_oe` stays all zeros even with `rd_n` low.
- R3: In serial mode, a write, data-write or read strobe that falls while the serial clock is low starts an access that samples data on rising serial clock edges.
- R4: In serial mode, a `cs_n` fall while the serial clock is high starts an access that samples data on falling serial clock edges.
- R5: In serial mode, `d_in[6]` is the serial clock and `d_in[7]` is the serial data. Bits arrive most significant first, and a byte is complete on the eighth sampled bit.
- R6: Raising `cs_n` discards a partly received serial byte. The next access starts counting from its first bit.
- R7: Each completed byte raises `byte_valid` for exactly one clock. `byte_tag` is 1 when the data-write strobe carried the byte; in serial mode that means `dw_n` was held low when the byte completed. Otherwise `byte_tag` is 0.
- R8: With `rd_n` and `cs_n` both low and `flash_rd_active` low, `d_out` is all zeros and `d_oe` is all ones.
- R9: With `rd_n` and `cs_n` both low and `flash_rd_active` high, `d_out` equals `flash_rd_data`.
- R10: `ready` is low while `nvm_busy` is high and high otherwise.
- R11: `d_oe` is all zeros whenever `rd_n` is high.
- R12: During and right after reset, `byte_valid` is 0 and the serial engine is idle, so a bit pattern alone yields no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_sel | input | 1 | Static mode: 1 selects serial, 0 selects parallel |
| cs_n | input | 1 | Active-low chip select gating all host activity |
| wr_n | input | 1 | Active-low write strobe |
| dw_n | input | 1 | Active-low data-write strobe |
| rd_n | input | 1 | Active-low read strobe |
| d_in | input | W | Bus input; bit 6 serial clock, bit 7 serial data in serial mode |
| d_out | output | W | Read-back data driven onto the bus |
| d_oe | output | W | Per-pin output enable for `d_out` |
| flash_rd_active | input | 1 | Storage read in progress |
| flash_rd_data | input | W | Data from the storage array |
| nvm_busy | input | 1 | Erase or program cycle running |
| ready | output | 1 | High when no erase or program cycle runs |
| byte_valid | output | 1 | One-cycle pulse per completed byte |
| byte_data | output | W | Completed byte |
| byte_tag | output | 1 | 1 when the data-write strobe carried the byte |

## Verification
A stimulus table drives bytes through three access shapes, each with and without the data-write strobe:

- parallel strobes;
- serial accesses opened by a strobe with the clock low;
- serial accesses opened by chip select with the clock high.

Byte values such as 0x80, 0x01, 0xA5 and 0x3C separate bit order, a shift by one and a swapped sampling edge from each other, because a wrong edge or a wrong count shifts or truncates the pattern. Directed cases cover the rest:

- strobes under a high chip select;
- a serial byte cut off by chip select and followed by a fresh one;
- read-back with and without an active storage read;
- the busy-to-ready mapping;
- output behaviour during reset.

// File: rtl/host_cmd_pkg.sv
`timescale 1ns/1ps
package host_cmd_pkg;
    // Pin roles on the shared bus while serial mode is selected.
    localparam int SCK_IDX = 6;
    localparam int SDI_IDX = 7;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_RISE = 2'd1,
        SER_FALL = 2'd2
    } ser_state_e;
endpackage

// File: rtl/hcp_sync.sv
`timescale 1ns/1ps
module hcp_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/hcp_ser_fsm.sv
`timescale 1ns/1ps
module hcp_ser_fsm
    import host_cmd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cs_q,
    input  logic         cs_fall,
    input  logic         strobe_fall,
    input  logic         sck_q,
    input  logic         sck_rise,
    input  logic         sck_fall,
    input  logic         sdi,
    input  logic         dw_act,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    output logic         tag_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    ser_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  shreg_q;
    logic          take;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SER_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE: begin
                if (en && !cs_q) begin
                    if (cs_fall && sck_q)           state_d = SER_FALL;
                    else if (strobe_fall && !sck_q) state_d = SER_RISE;
                end
            end
            SER_RISE, SER_FALL: begin
                if (cs_q || !en) state_d = SER_IDLE;
            end
            default: state_d = SER_IDLE;
        endcase
    end

    assign take = !cs_q && (((state_q == SER_RISE) && sck_rise) ||
                            ((state_q == SER_FALL) && sck_fall));

    // Outputs: bit counter, shifter, byte delivery
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            valid_o <= 1'b0;
            data_o  <= '0;
            tag_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (state_q == SER_IDLE || cs_q) begin
                cnt_q <= '0;
            end else if (take) begin
                shreg_q <= {shreg_q[W-2:0], sdi};
                if (cnt_q == LAST) begin
                    cnt_q   <= '0;
                    valid_o <= 1'b1;
                    data_o  <= {shreg_q[W-2:0], sdi};
                    tag_o   <= dw_act;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hcp_par_capture.sv
`timescale 1ns/1ps
module hcp_par_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         wr_rise,
    input  logic         dw_rise,
    input  logic [W-1:0] bus_q,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    output logic         tag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            tag_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (en && (wr_rise || dw_rise)) begin
                valid_o <= 1'b1;
                data_o  <= bus_q;
                tag_o   <= dw_rise;
            end
        end
    end
endmodule

// File: rtl/host_cmd_port.sv
`timescale 1ns/1ps
module host_cmd_port
    import host_cmd_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         serial_sel,
    input  logic         cs_n,
    input  logic         wr_n,
    input  logic         dw_n,
    input  logic         rd_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out,
    output logic [W-1:0] d_oe,
    input  logic         flash_rd_active,
    input  logic [W-1:0] flash_rd_data,
    input  logic         nvm_busy,
    output logic         ready,
    output logic         byte_valid,
    output logic [W-1:0] byte_data,
    output logic         byte_tag
);
    localparam int NCTL = 5;  // cs, wr, dw, rd, mode

    logic [NCTL-1:0] ctl_s;
    logic [W-1:0]    bus_s;
    logic            cs_s, wr_s, dw_s, rd_s, mode_s;
    logic            cs_p, wr_p, dw_p, rd_p, sck_p;
    logic            sck_s, sdi_s, sel_act;
    logic            wr_fall, dw_fall, rd_fall, wr_rise, dw_rise;
    logic            cs_fall, sck_rise, sck_fall;
    logic            ser_v, ser_t, par_v, par_t;
    logic [W-1:0]    ser_d, par_d;

    hcp_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(5'b11110)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({cs_n, wr_n, dw_n, rd_n, serial_sel}),
        .sync_o(ctl_s)
    );

    hcp_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .async_i(d_in), .sync_o(bus_s)
    );

    assign {cs_s, wr_s, dw_s, rd_s, mode_s} = ctl_s;
    assign sck_s   = bus_s[SCK_IDX];
    assign sdi_s   = bus_s[SDI_IDX];
    assign sel_act = !cs_s;

    // Previous-cycle copies for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {cs_p, wr_p, dw_p, rd_p} <= 4'b1111;
            sck_p                    <= 1'b0;
        end else begin
            {cs_p, wr_p, dw_p, rd_p} <= {cs_s, wr_s, dw_s, rd_s};
            sck_p                    <= sck_s;
        end
    end

    assign wr_fall  = sel_act && wr_p && !wr_s;
    assign dw_fall  = sel_act && dw_p && !dw_s;
    assign rd_fall  = sel_act && rd_p && !rd_s;
    assign wr_rise  = sel_act && !wr_p && wr_s;
    assign dw_rise  = sel_act && !dw_p && dw_s;
    assign cs_fall  = cs_p && !cs_s;
    assign sck_rise = !sck_p && sck_s;
    assign sck_fall = sck_p && !sck_s;

    hcp_ser_fsm #(.W(W)) u_ser (
        .clk(clk), .rst_n(rst_n), .en(mode_s), .cs_q(cs_s),
        .cs_fall(cs_fall), .strobe_fall(wr_fall || dw_fall || rd_fall),
        .sck_q(sck_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sdi(sdi_s), .dw_act(sel_act && !dw_s),
        .valid_o(ser_v), .data_o(ser_d), .tag_o(ser_t)
    );

    hcp_par_capture #(.W(W)) u_par (
        .clk(clk), .rst_n(rst_n), .en(!mode_s),
        .wr_rise(wr_rise), .dw_rise(dw_rise), .bus_q(bus_s),
        .valid_o(par_v), .data_o(par_d), .tag_o(par_t)
    );

    assign byte_valid = ser_v || par_v;
    assign byte_data  = ser_v ? ser_d : par_d;
    assign byte_tag   = ser_v ? ser_t : par_t;

    // Read-back path follows the host pins directly
    assign d_oe  = {W{!rd_n && !cs_n}};
    assign d_out = flash_rd_active ? flash_rd_data : '0;
    assign ready = !nvm_busy;
endmodule

// File: rtl/host_cmd_port_chk.sv
`timescale 1ns/1ps
module host_cmd_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         rd_n,
    input logic [W-1:0] d_out,
    input logic [W-1:0] d_oe,
    input logic         flash_rd_active,
    input logic [W-1:0] flash_rd_data,
    input logic         byte_valid
);
    p_one_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    p_cs_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !byte_valid);

    p_read_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !cs_n && !flash_rd_active) |-> (d_out == '0 && d_oe == '1));

    p_flash_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !cs_n && flash_rd_active) |-> (d_out == flash_rd_data));

    p_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (d_oe == '0));
endmodule

bind host_cmd_port host_cmd_port_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
    .d_out(d_out), .d_oe(d_oe), .flash_rd_active(flash_rd_active),
    .flash_rd_data(flash_rd_data), .byte_valid(byte_valid)
);

// File: tb/test_host_cmd_port.sv
`timescale 1ns/1ps
module test_host_cmd_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         serial_sel = 1'b0;
    logic         cs_n = 1'b1, wr_n = 1'b1, dw_n = 1'b1, rd_n = 1'b1;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] d_out, d_oe;
    logic         flash_rd_active = 1'b0;
    logic [W-1:0] flash_rd_data = '0;
    logic         nvm_busy = 1'b0;
    logic         ready, byte_valid, byte_tag;
    logic [W-1:0] byte_data;

    int n_chk = 0, n_bad = 0, n_pulse = 0;
    logic [W-1:0] got_b = '0;
    logic         got_t = 1'b0;
    bit           done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    host_cmd_port #(.W(W)) i_host_cmd_port (
        .clk(clk), .rst_n(rst_n), .serial_sel(serial_sel), .cs_n(cs_n),
        .wr_n(wr_n), .dw_n(dw_n), .rd_n(rd_n), .d_in(d_in),
        .d_out(d_out), .d_oe(d_oe), .flash_rd_active(flash_rd_active),
        .flash_rd_data(flash_rd_data), .nvm_busy(nvm_busy), .ready(ready),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_tag(byte_tag)
    );

    always @(posedge clk) begin
        if (byte_valid) begin
            n_pulse = n_pulse + 1;
            got_b   = byte_data;
            got_t   = byte_tag;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic par_xfer(input bit dw, input logic [7:0] b);
        wait_n(1); cs_n = 1'b0; d_in = b; wait_n(3);
        if (dw) dw_n = 1'b0; else wr_n = 1'b0;
        wait_n(4); wr_n = 1'b1; dw_n = 1'b1; wait_n(4);
        cs_n = 1'b1; wait_n(6);
    endtask

    // Strobe opens the access with clock low: rising-edge sampling
    task automatic ser_rise(input bit dw, input logic [7:0] b, input int nbits);
        wait_n(1); d_in[6] = 1'b0; cs_n = 1'b0; wait_n(3);
        if (dw) dw_n = 1'b0; else wr_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < nbits; i++) begin
            d_in[7] = b[7-i]; wait_n(3);
            d_in[6] = 1'b1; wait_n(3);
            d_in[6] = 1'b0;
        end
        wait_n(4); wr_n = 1'b1; dw_n = 1'b1; cs_n = 1'b1; wait_n(6);
    endtask

    // Chip select opens the access with clock high: falling-edge sampling
    task automatic ser_fall(input bit dw, input logic [7:0] b, input int nbits);
        wait_n(1); d_in[6] = 1'b1; wait_n(4); cs_n = 1'b0; wait_n(4);
        if (dw) dw_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < nbits; i++) begin
            d_in[7] = b[7-i]; wait_n(3);
            d_in[6] = 1'b0; wait_n(3);
            d_in[6] = 1'b1;
        end
        wait_n(4); dw_n = 1'b1; cs_n = 1'b1; wait_n(2); d_in[6] = 1'b0; wait_n(6);
    endtask

    // {shape[1:0] (0 parallel, 1 serial-rise, 2 serial-fall), use_dw, byte}
    localparam logic [10:0] VEC [12] = '{
        {2'd0, 1'b0, 8'hA5}, {2'd0, 1'b1, 8'h3C}, {2'd0, 1'b0, 8'h80}, {2'd0, 1'b1, 8'h01},
        {2'd1, 1'b0, 8'hA5}, {2'd1, 1'b1, 8'h3C}, {2'd1, 1'b0, 8'h80}, {2'd1, 1'b0, 8'h01},
        {2'd2, 1'b0, 8'hA5}, {2'd2, 1'b1, 8'h3C}, {2'd2, 1'b0, 8'h01}, {2'd2, 1'b1, 8'hFE}
    };

    initial begin
        // R12: reset state
        wait_n(3);
        check(byte_valid == 1'b0, "R12 valid in reset", int'(byte_valid), 0);
        check(d_oe == '0, "R11 oe in reset", int'(d_oe), 0);
        rst_n = 1'b1; wait_n(4);
        check(n_pulse == 0, "R12 no byte after reset", n_pulse, 0);

        // Table walk: R1 R3 R4 R5 R7
        for (int k = 0; k < 12; k++) begin
            automatic logic [1:0] shp = VEC[k][10:9];
            automatic bit         dwv = VEC[k][8];
            automatic logic [7:0] bv  = VEC[k][7:0];
            automatic int         p0  = n_pulse;
            serial_sel = (shp != 2'd0);
            wait_n(4);
            if (shp == 2'd0)      par_xfer(dwv, bv);
            else if (shp == 2'd1) ser_rise(dwv, bv, 8);
            else                  ser_fall(dwv, bv, 8);
            check(n_pulse == p0 + 1, "R7 one byte per access", n_pulse - p0, 1);
            check(got_b == bv, (shp == 0) ? "R1 parallel byte" :
                               (shp == 1) ? "R3 R5 rising-edge byte" : "R4 R5 falling-edge byte",
                  int'(got_b), int'(bv));
            check(got_t == dwv, "R7 tag", int'(got_t), int'(dwv));
        end

        // R2: strobes under high chip select
        begin
            automatic int p0 = n_pulse;
            serial_sel = 1'b0; wait_n(4);
            d_in = 8'h77; wr_n = 1'b0; wait_n(4); wr_n = 1'b1; wait_n(2);
            dw_n = 1'b0; wait_n(4); dw_n = 1'b1; wait_n(2);
            rd_n = 1'b0; wait_n(2);
            check(d_oe == '0, "R2 no drive with cs high", int'(d_oe), 0);
            rd_n = 1'b1; wait_n(6);
            check(n_pulse == p0, "R2 no byte with cs high", n_pulse - p0, 0);
        end

        // R1: parallel bus ignored in serial mode (no rising-sample access)
        begin
            automatic int p0 = n_pulse;
            serial_sel = 1'b1; wait_n(4);
            d_in = 8'h00; cs_n = 1'b0; wait_n(3);
            d_in = 8'h42; wr_n = 1'b0; wait_n(4); wr_n = 1'b1; wait_n(4);
            cs_n = 1'b1; d_in = '0; wait_n(6);
            check(n_pulse == p0, "R1 bus write ignored in serial mode", n_pulse - p0, 0);
        end

        // R6: partial byte discarded
        begin
            automatic int p0 = n_pulse;
            ser_rise(1'b0, 8'hF0, 4);
            check(n_pulse == p0, "R6 no byte from partial", n_pulse - p0, 0);
            ser_rise(1'b0, 8'h5A, 8);
            check(n_pulse == p0 + 1 && got_b == 8'h5A, "R6 fresh byte after cut", int'(got_b), 8'h5A);
        end

        // R8 R9 R11: read-back
        cs_n = 1'b0; rd_n = 1'b0; flash_rd_data = 8'hC3; wait_n(1);
        check(d_oe == 8'hFF && d_out == 8'h00, "R8 read without flash", int'(d_out), 0);
        flash_rd_active = 1'b1; wait_n(1);
        check(d_out == 8'hC3 && d_oe == 8'hFF, "R9 flash data out", int'(d_out), 8'hC3);
        rd_n = 1'b1; wait_n(1);
        check(d_oe == '0, "R11 no drive after read", int'(d_oe), 0);
        flash_rd_active = 1'b0; cs_n = 1'b1; wait_n(8);

        // R10: ready
        nvm_busy = 1'b1; wait_n(1);
        check(ready == 1'b0, "R10 busy", int'(ready), 0);
        nvm_busy = 1'b0; wait_n(1);
        check(ready == 1'b1, "R10 ready", int'(ready), 1);

        // R12: bit pattern during reset yields nothing
        begin
            automatic int p0 = n_pulse;
            rst_n = 1'b0; serial_sel = 1'b1; wait_n(2);
            ser_fall(1'b0, 8'h99, 8);
            rst_n = 1'b1; wait_n(6);
            check(n_pulse == p0, "R12 nothing during reset", n_pulse - p0, 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule